// File: doc/BRIEF.md
# Filtered Staged Reset Sequencer

This block turns an asynchronous, active-low external reset pin into three registered reset controls for the rest of the chip, all timed in bus-clock cycles. The raw pin first passes through a two-flop synchroniser. A low-run counter then qualifies it, so a low level counts only once it has been seen for a programmable number of consecutive clock edges. Shorter dips are dropped without trace. A qualified reset raises the pin-domain reset and the internal bus-hold request together. The core reset follows a fixed number of cycles later. Release is staged in the opposite order: the pin reset and bus-hold request fall first, after a release delay measured from the pin going high, and the core reset falls a further fixed delay after that.

A five-state machine drives the outputs. IDLE means everything is released. In ARM, the pin reset and bus hold are asserted and the core-assert delay is running. In HELD, everything is asserted and the machine waits for the qualified reset to drop. In PIN_WAIT, the pin-release delay is running with everything still asserted. In CORE_WAIT, the pin reset and bus hold have been released and the core-release delay is running. The transitions are named as follows. Qualify takes IDLE to ARM. Arm-done takes ARM to HELD. Release takes HELD to PIN_WAIT. Pin-done takes PIN_WAIT to CORE_WAIT. Core-done takes CORE_WAIT to IDLE. Re-qualify takes PIN_WAIT or CORE_WAIT back to HELD. At power-up the machine sits in HELD with all outputs asserted. The pin-reset output is meant to be wired as the reset of the port-related registers.

Top module: `staged_reset_seq`

## Requirements
- R1: At power-up, before any clock edge, all three outputs are 1. With the pin held high from the start, pin_reset and bus_hold_req fall at rising edge PIN_REL_DLY (counting the first edge as 1), and core_reset falls CORE_REL_DLY edges after that.
- R2: A low pulse on rst_pin_n sampled low at fewer than FILT_CYC consecutive rising edges has no effect on any output.
- R3: A low pulse sampled low at FILT_CYC or more consecutive edges raises pin_reset and bus_hold_req FILT_CYC+2 edges after the first edge that samples the pin low.
- R4: pin_reset and bus_hold_req are equal in every cycle.
- R5: core_reset rises exactly ASSERT_DLY edges after pin_reset rises.
- R6: While the pin stays low, all asserted outputs remain asserted.
- R7: Once the core reset has been asserted, pin_reset and bus_hold_req fall at the PIN_REL_DLY-th edge, counting the first edge that samples the pin high as edge 1.
- R8: core_reset falls exactly CORE_REL_DLY edges after pin_reset falls.
- R9: A qualified low during the pin-release wait keeps all outputs asserted, and the release timing restarts from the next high level.
- R10: A qualified low during the core-release wait raises pin_reset and bus_hold_req again after the R3 latency, with core_reset held at 1 throughout. Release then restarts as in R7 and R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all outputs change only on its rising edge |
| rst_pin_n | input | 1 | Asynchronous external reset pin, active low |
| pin_reset | output | 1 | Reset for pin-side and port-related registers, active high |
| bus_hold_req | output | 1 | Internal bus-hold request, active high |
| core_reset | output | 1 | Reset for the core and internal logic, active high |

## Verification
Every result is due a fixed number of edges after a pin change. The pin reset rises FILT_CYC+2 edges after the first low sample. The core reset rises ASSERT_DLY edges after that. The pin reset falls at edge PIN_REL_DLY, counting the first high sample as edge 1, or three edges after the arm delay ends if the pin is released early. The core reset falls CORE_REL_DLY edges after the pin reset. The bench drives the pin on falling edges, numbers every rising edge from the start of a scenario, and builds an expected output for each edge index from these sums. It samples on the next falling edge and compares every output at every edge. Pulse lengths are swept from one cycle to beyond the arm delay, so that both the filter boundary and the early-release case are covered.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE      = 3'd0,
        SQ_ARM       = 3'd1,
        SQ_HELD      = 3'd2,
        SQ_PIN_WAIT  = 3'd3,
        SQ_CORE_WAIT = 3'd4
    } seq_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync (
    input  logic clk,
    input  logic async_in,
    output logic sync_out
);
    // Power-up value 0 reads as "reset present" until the pin is sampled.
    logic stage1 = 1'b0;
    logic stage2 = 1'b0;

    always_ff @(posedge clk) begin
        stage1 <= async_in;
        stage2 <= stage1;
    end

    assign sync_out = stage2;
endmodule

// File: rtl/rstseq_filter.sv
module rstseq_filter #(
    parameter int FILT_CYC = 50
) (
    input  logic clk,
    input  logic pin_sync,
    output logic rst_qual
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(FILT_CYC);
    localparam logic [CW-1:0] RUN_LAST = CW'(FILT_CYC - 1);

    // The counter starts saturated so that power-up reads as a qualified reset.
    logic [CW-1:0] low_run = RUN_MAX;
    logic          qual_q  = 1'b1;

    always_ff @(posedge clk) begin
        if (pin_sync) begin
            low_run <= '0;
            qual_q  <= 1'b0;
        end else if (low_run != RUN_MAX) begin
            low_run <= low_run + 1'b1;
            qual_q  <= (low_run == RUN_LAST);
        end else begin
            qual_q  <= 1'b1;
        end
    end

    assign rst_qual = qual_q;
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         restart,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_q = '0;

    always_ff @(posedge clk) begin
        if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != {W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/staged_reset_seq.sv
module staged_reset_seq #(
    parameter int FILT_CYC     = 50,
    parameter int ASSERT_DLY   = 9,
    parameter int PIN_REL_DLY  = 17,
    parameter int CORE_REL_DLY = 15
) (
    input  logic clk,
    input  logic rst_pin_n,
    output logic pin_reset,
    output logic bus_hold_req,
    output logic core_reset
);
    import rstseq_pkg::*;

    // Sync (2) plus filter (1) plus state register (1) precede the pin-wait count.
    localparam int PIN_WAIT_CYC = PIN_REL_DLY - 4;
    localparam int TW = $clog2(max3(ASSERT_DLY, PIN_WAIT_CYC, CORE_REL_DLY) + 1);
    localparam logic [TW-1:0] ARM_LAST  = TW'(ASSERT_DLY - 1);
    localparam logic [TW-1:0] PIN_LAST  = TW'(PIN_WAIT_CYC - 1);
    localparam logic [TW-1:0] CORE_LAST = TW'(CORE_REL_DLY - 1);

    logic          pin_sync;
    logic          rst_qual;
    logic [TW-1:0] tcount;
    logic          restart;

    seq_state_t state = SQ_HELD;
    seq_state_t nxt;

    logic pin_q  = 1'b1;
    logic hold_q = 1'b1;
    logic core_q = 1'b1;

    rstseq_sync u_sync (
        .clk      (clk),
        .async_in (rst_pin_n),
        .sync_out (pin_sync)
    );

    rstseq_filter #(.FILT_CYC(FILT_CYC)) u_filter (
        .clk      (clk),
        .pin_sync (pin_sync),
        .rst_qual (rst_qual)
    );

    rstseq_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .restart (restart),
        .count   (tcount)
    );

    // Next-state logic: named transitions.
    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE: begin
                if (rst_qual) nxt = SQ_ARM;                  // qualify
            end
            SQ_ARM: begin
                if (tcount == ARM_LAST) nxt = SQ_HELD;       // arm-done
            end
            SQ_HELD: begin
                if (!rst_qual) nxt = SQ_PIN_WAIT;            // release
            end
            SQ_PIN_WAIT: begin
                if (rst_qual) nxt = SQ_HELD;                 // re-qualify
                else if (tcount == PIN_LAST) nxt = SQ_CORE_WAIT; // pin-done
            end
            SQ_CORE_WAIT: begin
                if (rst_qual) nxt = SQ_HELD;                 // re-qualify
                else if (tcount == CORE_LAST) nxt = SQ_IDLE; // core-done
            end
            default: nxt = SQ_HELD;
        endcase
    end

    assign restart = (nxt != state);

    // State register.
    always_ff @(posedge clk) begin
        state <= nxt;
    end

    // Output registers, loaded from the next state so they match the state register.
    always_ff @(posedge clk) begin
        pin_q  <= (nxt == SQ_ARM) || (nxt == SQ_HELD) || (nxt == SQ_PIN_WAIT);
        hold_q <= (nxt == SQ_ARM) || (nxt == SQ_HELD) || (nxt == SQ_PIN_WAIT);
        core_q <= (nxt == SQ_HELD) || (nxt == SQ_PIN_WAIT) || (nxt == SQ_CORE_WAIT);
    end

    assign pin_reset    = pin_q;
    assign bus_hold_req = hold_q;
    assign core_reset   = core_q;
endmodule

// File: rtl/staged_reset_seq_checker.sv
module staged_reset_seq_checker #(
    parameter int ASSERT_DLY   = 9,
    parameter int CORE_REL_DLY = 15
) (
    input logic clk,
    input logic pin_reset,
    input logic bus_hold_req,
    input logic core_reset
);
    localparam int AW = $clog2(ASSERT_DLY + 2);
    localparam int CWD = $clog2(CORE_REL_DLY + 2);

    logic           primed   = 1'b0;
    logic [AW-1:0]  arm_run  = '0;
    logic [CWD-1:0] core_run = '0;

    always_ff @(posedge clk) begin
        primed <= 1'b1;
        if (pin_reset && !core_reset) begin
            if (arm_run != {AW{1'b1}}) arm_run <= arm_run + 1'b1;
        end else begin
            arm_run <= '0;
        end
        if (!pin_reset && core_reset) begin
            if (core_run != {CWD{1'b1}}) core_run <= core_run + 1'b1;
        end else begin
            core_run <= '0;
        end
    end

    a_r4_pin_bus_match: assert property (@(posedge clk) disable iff (!primed)
        pin_reset == bus_hold_req);

    a_r5_core_rise_delay: assert property (@(posedge clk) disable iff (!primed)
        $rose(core_reset) |-> (arm_run == AW'(ASSERT_DLY)));

    a_r5_core_rise_under_pin: assert property (@(posedge clk) disable iff (!primed)
        $rose(core_reset) |-> (pin_reset && $past(pin_reset)));

    a_r8_core_fall_delay: assert property (@(posedge clk) disable iff (!primed)
        $fell(core_reset) |-> (core_run == CWD'(CORE_REL_DLY)));

    a_r8_pin_falls_first: assert property (@(posedge clk) disable iff (!primed)
        $fell(pin_reset) |-> core_reset);
endmodule

bind staged_reset_seq staged_reset_seq_checker #(
    .ASSERT_DLY   (ASSERT_DLY),
    .CORE_REL_DLY (CORE_REL_DLY)
) u_chk (
    .clk          (clk),
    .pin_reset    (pin_reset),
    .bus_hold_req (bus_hold_req),
    .core_reset   (core_reset)
);

// File: tb/staged_reset_seq_test.sv
module staged_reset_seq_test;
    localparam int F  = 3;
    localparam int AD = 9;
    localparam int PR = 17;
    localparam int CD = 15;
    localparam int N  = 100;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_pin_n = 1'b1;
    logic pin_reset, bus_hold_req, core_reset;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    bit    drv [0:N];
    bit    ep  [0:N];
    bit    ec  [0:N];
    string tp  [0:N];
    string tc  [0:N];

    staged_reset_seq #(
        .FILT_CYC(F), .ASSERT_DLY(AD), .PIN_REL_DLY(PR), .CORE_REL_DLY(CD)
    ) uut (
        .clk(clk), .rst_pin_n(rst_pin_n),
        .pin_reset(pin_reset), .bus_hold_req(bus_hold_req), .core_reset(core_reset)
    );

    task automatic check_bit(input string tag, input string what, input int edge_no,
                             input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s edge=%0d actual=%b expected=%b", tag, what, edge_no, act, exp);
        end
    endtask

    task automatic clear_trace();
        for (int j = 0; j <= N; j++) begin
            drv[j] = 1'b1; ep[j] = 1'b0; ec[j] = 1'b0;
            tp[j] = "R7"; tc[j] = "R8";
        end
    endtask

    // Drives drv[j] before edge j, samples after edge j on the falling edge.
    task automatic run_trace();
        for (int j = 1; j <= N; j++) begin
            rst_pin_n = drv[j];
            @(posedge clk);
            @(negedge clk);
            check_bit(tp[j], "pin_reset", j, pin_reset, ep[j]);
            check_bit(tc[j], "core_reset", j, core_reset, ec[j]);
            check_bit("R4", "bus_hold_req", j, bus_hold_req, pin_reset);
        end
    endtask

    initial begin
        #1;
        // R1: power-up values before any edge.
        check_bit("R1", "pin_reset", 0, pin_reset, 1'b1);
        check_bit("R1", "bus_hold_req", 0, bus_hold_req, 1'b1);
        check_bit("R1", "core_reset", 0, core_reset, 1'b1);

        // R1: power-up release with the pin high from the start.
        clear_trace();
        for (int j = 1; j <= N; j++) begin
            ep[j] = (j < PR);
            ec[j] = (j < PR + CD);
            tp[j] = "R1"; tc[j] = "R1";
        end
        run_trace();

        // Sweep of low-pulse lengths from idle: R2, R3, R5, R6, R7, R8.
        for (int len = 1; len <= F + AD + 3; len++) begin
            int e_rel;
            clear_trace();
            for (int j = 1; j <= len; j++) drv[j] = 1'b0;
            e_rel = (len + 4 > F + 4 + AD) ? len + 4 : F + 4 + AD;
            for (int j = 1; j <= N; j++) begin
                if (len < F) begin
                    tp[j] = "R2"; tc[j] = "R2";
                end else begin
                    ep[j] = (j >= F + 3) && (j <= e_rel + PR - 5);
                    ec[j] = (j >= F + 3 + AD) && (j <= e_rel + PR - 5 + CD);
                    tp[j] = (j <= F + 3) ? "R3" : ((j <= len) ? "R6" : "R7");
                    tc[j] = (j <= F + 3 + AD) ? "R5" : ((j <= len) ? "R6" : "R8");
                end
            end
            run_trace();
        end

        // R9: qualified low during the pin-release wait.
        clear_trace();
        for (int j = 1; j <= 20; j++) drv[j] = 1'b0;
        for (int j = 25; j <= 28; j++) drv[j] = 1'b0;
        for (int j = 1; j <= N; j++) begin
            ep[j] = (j >= 6) && (j <= 44);
            ec[j] = (j >= 15) && (j <= 59);
            tp[j] = "R9"; tc[j] = "R9";
        end
        run_trace();

        // R10: qualified low during the core-release wait.
        clear_trace();
        for (int j = 1; j <= 20; j++) drv[j] = 1'b0;
        for (int j = 40; j <= 43; j++) drv[j] = 1'b0;
        for (int j = 1; j <= N; j++) begin
            ep[j] = ((j >= 6) && (j <= 36)) || ((j >= 45) && (j <= 59));
            ec[j] = (j >= 15) && (j <= 74);
            tp[j] = "R10"; tc[j] = "R10";
        end
        run_trace();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule